// File: doc/BRIEF.md
# Ping-Pong Mirrored Register File

This block is a register file made of two identical banks that share one register namespace. At any moment one bank is active. The functional unit reads three operands from the active bank and writes one result into it. Meanwhile the load/store unit streams the next data set into the other bank through its own write port. Neither bank needs more than one write port. Loads at up to one word per cycle overlap arithmetic with no stall, which covers a coefficient plus a sample for every multiply-accumulate that takes two cycles.

A one-cycle swap pulse exchanges the roles of the two banks. The data just loaded then becomes the operand set for the functional unit, and the bank it was working in becomes free for the next load. Both write ports are plain enable/address/data ports that accept a write every cycle, so there is no back-pressure and no ready signal. The roles follow a single selection bit, and both banks can be written in the same cycle without conflict.

Top module: `pingpong_rf`

## Requirements
- R1: After reset the active-bank output is 0, meaning bank 0 serves the functional unit. Register contents are not cleared.
- R2: A one-cycle high on `swap_i` inverts the active bank at that clock edge. While `swap_i` is low the active bank holds its value.
- R3: Each of the three read ports returns, combinationally, the word that the active bank holds at its own address. The ports are independent and any address is allowed on any port.
- R4: A functional-unit write with `fu_we_i` high stores `fu_wr_data_i` at `fu_wr_addr_i` in the active bank at the clock edge. It is visible on the read ports from the next cycle.
- R5: A load/store write stores into the inactive bank only. No word that the read ports can see is changed by it.
- R6: A functional-unit write and a load/store write in the same cycle, even to the same address, both take effect, each in its own bank.
- R7: A read of an address that is being written in the same cycle returns the old contents until the clock edge.
- R8: Writes issued in the same cycle as a swap pulse use the bank roles that held before the swap.
- R9: After a swap, the words loaded through the load/store port appear on the read ports. The words the functional unit wrote before the swap reappear after a second swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| swap_i | input | 1 | One-cycle pulse that exchanges bank roles |
| active_bank_o | output | 1 | Index of the bank serving the functional unit |
| fu_rd_addr0_i | input | 4 | Read port 0 address |
| fu_rd_addr1_i | input | 4 | Read port 1 address |
| fu_rd_addr2_i | input | 4 | Read port 2 address |
| fu_rd_data0_o | output | 16 | Read port 0 data |
| fu_rd_data1_o | output | 16 | Read port 1 data |
| fu_rd_data2_o | output | 16 | Read port 2 data |
| fu_we_i | input | 1 | Functional-unit write enable |
| fu_wr_addr_i | input | 4 | Functional-unit write address |
| fu_wr_data_i | input | 16 | Functional-unit write data |
| ls_we_i | input | 1 | Load/store write enable |
| ls_wr_addr_i | input | 4 | Load/store write address |
| ls_wr_data_i | input | 16 | Load/store write data |

## Verification
Read data is due in the same cycle as its address. The bench therefore sets the addresses just after a falling edge and samples a moment later, with no clock edge in between. Writes and swaps take effect at the next rising edge. Their results, including the new `active_bank_o`, are sampled in the low phase after that edge, one cycle after the stimulus. The contents of the inactive bank can only be seen through the ports, so the bench checks them after a swap, comparing against two model arrays that it updates by the bank-role rules.

// File: rtl/pprf_pkg.sv
package pprf_pkg;

  // Identity of a physical bank
  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;

  localparam int unsigned NUM_BANKS = 2;

  function automatic bank_e other_bank(input bank_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction

endpackage

// File: rtl/pprf_bank_sel.sv
module pprf_bank_sel
  import pprf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  swap_i,
  output bank_e active_o
);

  bank_e active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      active_q <= BANK_A;
    else if (swap_i) active_q <= other_bank(active_q);
  end

  assign active_o = active_q;

  // R2
  swap_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_i |=> (active_o != $past(active_o)));

  // R2
  swap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_i |=> $stable(active_o));

endmodule

// File: rtl/pprf_write_steer.sv
module pprf_write_steer
  import pprf_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  bank_e                                active_i,
  input  logic                                 fu_we_i,
  input  logic [ADDR_W-1:0]                    fu_addr_i,
  input  logic [DATA_W-1:0]                    fu_data_i,
  input  logic                                 ls_we_i,
  input  logic [ADDR_W-1:0]                    ls_addr_i,
  input  logic [DATA_W-1:0]                    ls_data_i,
  output logic [NUM_BANKS-1:0]                 bank_we_o,
  output logic [NUM_BANKS-1:0][ADDR_W-1:0]     bank_addr_o,
  output logic [NUM_BANKS-1:0][DATA_W-1:0]     bank_data_o
);

  // Each bank's single write port is owned either by the functional
  // unit (bank is active) or by the load/store unit (bank is idle).
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_steer
    logic owned_by_fu;
    assign owned_by_fu = (active_i == bank_e'(b));

    always_comb begin
      if (owned_by_fu) begin
        bank_we_o[b]   = fu_we_i;
        bank_addr_o[b] = fu_addr_i;
        bank_data_o[b] = fu_data_i;
      end else begin
        bank_we_o[b]   = ls_we_i;
        bank_addr_o[b] = ls_addr_i;
        bank_data_o[b] = ls_data_i;
      end
    end
  end

  // R5
  ls_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_we_i && !fu_we_i) |-> (bank_we_o[active_i] == 1'b0));

  // R6
  dual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_we_i && fu_we_i) |-> ($countones(bank_we_o) == 2));

endmodule

// File: rtl/pprf_bank.sv
module pprf_bank #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned NUM_RD   = 3,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 waddr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]     raddr_i,
  output logic [NUM_RD-1:0][DATA_W-1:0]     rdata_o
);

  logic [DATA_W-1:0] mem_q [NUM_REGS];

  // Contents are intentionally not reset
  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rdata_o[p] = mem_q[raddr_i[p]];
  end

  // R4
  bank_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));

endmodule

// File: rtl/pingpong_rf.sv
module pingpong_rf
  import pprf_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS),
  localparam int unsigned NUM_RD  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swap_i,
  output logic              active_bank_o,
  input  logic [ADDR_W-1:0] fu_rd_addr0_i,
  input  logic [ADDR_W-1:0] fu_rd_addr1_i,
  input  logic [ADDR_W-1:0] fu_rd_addr2_i,
  output logic [DATA_W-1:0] fu_rd_data0_o,
  output logic [DATA_W-1:0] fu_rd_data1_o,
  output logic [DATA_W-1:0] fu_rd_data2_o,
  input  logic              fu_we_i,
  input  logic [ADDR_W-1:0] fu_wr_addr_i,
  input  logic [DATA_W-1:0] fu_wr_data_i,
  input  logic              ls_we_i,
  input  logic [ADDR_W-1:0] ls_wr_addr_i,
  input  logic [DATA_W-1:0] ls_wr_data_i
);

  bank_e                               active;
  logic [NUM_BANKS-1:0]                bank_we;
  logic [NUM_BANKS-1:0][ADDR_W-1:0]    bank_addr;
  logic [NUM_BANKS-1:0][DATA_W-1:0]    bank_data;
  logic [NUM_RD-1:0][ADDR_W-1:0]       rd_addr;
  logic [NUM_BANKS-1:0][NUM_RD-1:0][DATA_W-1:0] bank_rdata;
  logic [NUM_RD-1:0][DATA_W-1:0]       rd_data;

  pprf_bank_sel u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .swap_i   (swap_i),
    .active_o (active)
  );

  pprf_write_steer #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_steer (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_i    (active),
    .fu_we_i     (fu_we_i),
    .fu_addr_i   (fu_wr_addr_i),
    .fu_data_i   (fu_wr_data_i),
    .ls_we_i     (ls_we_i),
    .ls_addr_i   (ls_wr_addr_i),
    .ls_data_i   (ls_wr_data_i),
    .bank_we_o   (bank_we),
    .bank_addr_o (bank_addr),
    .bank_data_o (bank_data)
  );

  assign rd_addr[0] = fu_rd_addr0_i;
  assign rd_addr[1] = fu_rd_addr1_i;
  assign rd_addr[2] = fu_rd_addr2_i;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    pprf_bank #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS),
      .NUM_RD   (NUM_RD)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (bank_we[b]),
      .waddr_i (bank_addr[b]),
      .wdata_i (bank_data[b]),
      .raddr_i (rd_addr),
      .rdata_o (bank_rdata[b])
    );
  end

  // Operand select: every read port looks at the active bank only
  for (genvar p = 0; p < NUM_RD; p++) begin : g_rmux
    assign rd_data[p] = bank_rdata[active][p];
  end

  assign fu_rd_data0_o = rd_data[0];
  assign fu_rd_data1_o = rd_data[1];
  assign fu_rd_data2_o = rd_data[2];
  assign active_bank_o = active;

  // R4
  fu_write_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fu_we_i && !swap_i) |=>
      ((fu_rd_addr0_i != $past(fu_wr_addr_i)) || (fu_rd_data0_o == $past(fu_wr_data_i))));

  // R5
  ls_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fu_we_i && !swap_i) |=>
      (!$stable(fu_rd_addr1_i) || $stable(fu_rd_data1_o)));

endmodule

// File: tb/pingpong_rf_tb.sv
module pingpong_rf_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        swap_i = 1'b0;
  logic        active_bank_o;
  logic [3:0]  ra0 = '0, ra1 = '0, ra2 = '0;
  logic [15:0] rd0, rd1, rd2;
  logic        fu_we = 1'b0;
  logic [3:0]  fu_wa = '0;
  logic [15:0] fu_wd = '0;
  logic        ls_we = 1'b0;
  logic [3:0]  ls_wa = '0;
  logic [15:0] ls_wd = '0;

  int checks = 0;
  int errors = 0;
  logic [15:0] m0 [16];
  logic [15:0] m1 [16];

  always #10 clk = ~clk;

  pingpong_rf u_dut (
    .clk(clk), .rst_n(rst_n), .swap_i(swap_i), .active_bank_o(active_bank_o),
    .fu_rd_addr0_i(ra0), .fu_rd_addr1_i(ra1), .fu_rd_addr2_i(ra2),
    .fu_rd_data0_o(rd0), .fu_rd_data1_o(rd1), .fu_rd_data2_o(rd2),
    .fu_we_i(fu_we), .fu_wr_addr_i(fu_wa), .fu_wr_data_i(fu_wd),
    .ls_we_i(ls_we), .ls_wr_addr_i(ls_wa), .ls_wr_data_i(ls_wd)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic bank, input logic [3:0] a);
    return bank ? m1[a] : m0[a];
  endfunction

  // Advance one rising edge, return in the low phase
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic read3(input string req, input logic bank, input logic [3:0] a);
    ra0 = a; ra1 = a + 4'd5; ra2 = a + 4'd11;
    #1;
    check(req, rd0, exp_rd(bank, ra0));
    check(req, rd1, exp_rd(bank, ra1));
    check(req, rd2, exp_rd(bank, ra2));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: bank 0 active after reset
    check("R1", {15'd0, active_bank_o}, 16'd0);

    // R6: fill both banks in one sweep, FU into active (0), LS into idle (1)
    for (int a = 0; a < 16; a++) begin
      fu_we = 1'b1; fu_wa = 4'(a); fu_wd = 16'h5000 + 16'(a * 3);
      ls_we = 1'b1; ls_wa = 4'(a); ls_wd = 16'hA000 ^ 16'(a * 37);
      m0[a] = fu_wd; m1[a] = ls_wd;
      step();
    end
    fu_we = 1'b0; ls_we = 1'b0;

    // R3 R4 R5: active bank shows only FU-written words
    for (int a = 0; a < 16; a++) read3("R3", 1'b0, 4'(a));

    // R5: LS writes into idle bank leave visible words unchanged
    ra1 = 4'd9;
    for (int a = 0; a < 16; a++) begin
      ls_we = 1'b1; ls_wa = 4'(a); ls_wd = 16'hC300 + 16'(a);
      m1[a] = ls_wd;
      step();
      check("R5", rd1, m0[9]);
    end
    ls_we = 1'b0;

    // R7: read during write returns old value, new value after edge
    ra0 = 4'd3; fu_we = 1'b1; fu_wa = 4'd3; fu_wd = 16'hBEEF;
    #1;
    check("R7", rd0, m0[3]);
    step();
    fu_we = 1'b0; m0[3] = 16'hBEEF;
    check("R4", rd0, 16'hBEEF);

    // R8: writes in the swap cycle use the pre-swap roles
    swap_i = 1'b1;
    fu_we = 1'b1; fu_wa = 4'd7; fu_wd = 16'h1111;
    ls_we = 1'b1; ls_wa = 4'd7; ls_wd = 16'h2222;
    m0[7] = 16'h1111; m1[7] = 16'h2222;
    step();
    swap_i = 1'b0; fu_we = 1'b0; ls_we = 1'b0;
    // R2: swap toggled bank to 1
    check("R2", {15'd0, active_bank_o}, 16'd1);
    ra0 = 4'd7; #1;
    check("R8", rd0, 16'h2222);
    // R9: loaded data now visible
    for (int a = 0; a < 16; a++) read3("R9", 1'b1, 4'(a));

    // R2: no swap keeps bank
    repeat (4) begin
      step();
      check("R2", {15'd0, active_bank_o}, 16'd1);
    end

    // R4: FU writes now land in bank 1
    fu_we = 1'b1; fu_wa = 4'd12; fu_wd = 16'h7E57; m1[12] = 16'h7E57;
    step();
    fu_we = 1'b0;
    ra0 = 4'd12; #1;
    check("R4", rd0, 16'h7E57);

    // R9: second swap brings back the FU-written set, including R8 word
    swap_i = 1'b1;
    step();
    swap_i = 1'b0;
    check("R2", {15'd0, active_bank_o}, 16'd0);
    ra0 = 4'd7; #1;
    check("R8", rd0, 16'h1111);
    for (int a = 0; a < 16; a++) read3("R9", 1'b0, 4'(a));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule